// File: doc/BRIEF.md
# Channel Threshold Multiplicity Encoder

This block watches a group of digitised channels in real time and turns their coincident activity into a single analog amplitude code. Each channel has a threshold that software programs. When a channel's sample rises across that threshold, the block starts a pulse of fixed length for that channel. On every clock the block counts how many channel pulses are active. It places that count into one 4-bit field of a 16-bit DAC word, so the height of the analog output shows how many channels are firing together.

Software chooses the field position, which sets the scale of the output: each step of the count is worth 1, 16, 256 or 4096 DAC codes. The result can serve as a fast multiplicity input to a system-wide trigger. A global enable stops all pulses and holds the DAC word at zero. The DAC itself is outside this block. Samples arrive on every clock. The pulse length is a build-time parameter and cannot be changed by software.

Top module: `chanMultiplicityDac`

## Requirements
- R1: While reset is asserted, `dacCode` is zero. After reset is released, all channel pulses start inactive.
- R2: A crossing on a channel occurs when its previous sample was less than or equal to its threshold and its current sample is greater than that threshold. A sample that stays above the threshold does not start a new pulse.
- R3: A crossing seen at the clock edge that captures the sample makes the channel's pulse active for exactly `PULSE_LEN` clock cycles. The pulse shows up in `dacCode` one clock after that edge.
- R4: A new crossing on a channel whose pulse is still active reloads the pulse to the full `PULSE_LEN` cycles.
- R5: The count carried in `dacCode` is the number of channels whose pulses were active in the previous cycle, from 0 to 8. `dacCode` is a register.
- R6: `fieldSel` value s (0..3) places the count in bits [4s+3:4s] of `dacCode`. All other bits are zero.
- R7: When `enable` is low at a clock edge, every pulse is cleared and `dacCode` becomes zero at that edge. Crossings seen while `enable` is low start no pulse.
- R8: Each channel is compared only against its own threshold. The thresholds are independent of one another.
- R9: A sample equal to its threshold is not above it and does not cause a crossing.
- R10: The first sample after reset never causes a crossing. The previous-sample history resets to the full-scale code 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global enable; low clears pulses and zeroes the output |
| sampleBus | input | 64 | Eight 8-bit unsigned samples; channel c in bits [8c+7:8c] |
| thresholdBus | input | 64 | Eight 8-bit thresholds; channel c in bits [8c+7:8c] |
| fieldSel | input | 2 | Chooses which 4-bit field of the DAC word holds the count |
| dacCode | output | 16 | Registered DAC word |

## Verification
Two events can land in the same cycle: a channel retriggers while its pulse is still counting down, and other channels cross for the first time. Both change the count that must appear in the output. The bench provokes this with directed sequences that re-cross a channel two cycles into its pulse while neighbouring channels cross. It also uses random samples held close to random thresholds, with the field selection and the enable changing while pulses are live. Each output word is judged against a cycle-level model in the bench, built from the requirements. That model tracks the previous sample and the remaining pulse length of every channel.

// File: rtl/multDacPkg.sv
package multDacPkg;
  localparam int SEL_W = 2;

  typedef struct packed {
    logic             clearAll;
    logic             outEnable;
    logic [SEL_W-1:0] fieldSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/multCtrl.sv
module multCtrl
  import multDacPkg::*;
(
  input  logic             enable,
  input  logic [SEL_W-1:0] fieldSel,
  output ctrlStrobes_t     strobes
);
  always_comb begin
    strobes.clearAll  = ~enable;
    strobes.outEnable = enable;
    strobes.fieldSel  = fieldSel;
  end
endmodule

// File: rtl/chanPulse.sv
module chanPulse #(
  parameter int SAMPLE_W  = 8,
  parameter int PULSE_LEN = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clearAll,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] threshold,
  output logic                pulseOn
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(PULSE_LEN);

  logic [SAMPLE_W-1:0] prevSample;
  logic [CNT_W-1:0]    remain;
  logic                crossing;

  // rising edge across the threshold
  assign crossing = (prevSample <= threshold) && (sample > threshold);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= '1;
    end else begin
      prevSample <= sample;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (clearAll) begin
      remain <= '0;
    end else if (crossing) begin
      remain <= LOAD_VAL;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign pulseOn = (remain != '0);
endmodule

// File: rtl/multDatapath.sv
module multDatapath
  import multDacPkg::*;
#(
  parameter int NUM_CHAN = 8,
  parameter int FIELD_W  = 4,
  parameter int DAC_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [NUM_CHAN-1:0] pulseVec,
  output logic [DAC_W-1:0]    dacCode
);
  localparam int NUM_FIELDS = DAC_W / FIELD_W;
  localparam int SUM_W      = $clog2(NUM_CHAN + 1);
  localparam logic [FIELD_W-1:0] FIELD_MAX = '1;

  logic [SUM_W-1:0]   activeSum;
  logic [FIELD_W-1:0] fieldVal;
  logic [DAC_W-1:0]   nextCode;

  always_comb begin
    activeSum = '0;
    for (int c = 0; c < NUM_CHAN; c++) begin
      activeSum = activeSum + SUM_W'(pulseVec[c]);
    end
  end

  generate
    if (SUM_W > FIELD_W) begin : g_sat
      always_comb begin
        if (activeSum > SUM_W'(FIELD_MAX)) fieldVal = FIELD_MAX;
        else                               fieldVal = activeSum[FIELD_W-1:0];
      end
    end else begin : g_fit
      assign fieldVal = FIELD_W'(activeSum);
    end
  endgenerate

  always_comb begin
    nextCode = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (int'(strobes.fieldSel) == f) begin
        nextCode[f*FIELD_W +: FIELD_W] = fieldVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode <= '0;
    end else if (!strobes.outEnable) begin
      dacCode <= '0;
    end else begin
      dacCode <= nextCode;
    end
  end
endmodule

// File: rtl/chanMultiplicityDac.sv
module chanMultiplicityDac
  import multDacPkg::*;
#(
  parameter int NUM_CHAN  = 8,
  parameter int SAMPLE_W  = 8,
  parameter int PULSE_LEN = 5,
  parameter int FIELD_W   = 4,
  parameter int DAC_W     = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enable,
  input  logic [NUM_CHAN*SAMPLE_W-1:0] sampleBus,
  input  logic [NUM_CHAN*SAMPLE_W-1:0] thresholdBus,
  input  logic [SEL_W-1:0]             fieldSel,
  output logic [DAC_W-1:0]             dacCode
);
  ctrlStrobes_t        strobes;
  logic [NUM_CHAN-1:0] pulseVec;

  multCtrl u_ctrl (
    .enable   (enable),
    .fieldSel (fieldSel),
    .strobes  (strobes)
  );

  generate
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      chanPulse #(
        .SAMPLE_W  (SAMPLE_W),
        .PULSE_LEN (PULSE_LEN)
      ) u_pulse (
        .clk       (clk),
        .rstN      (rstN),
        .clearAll  (strobes.clearAll),
        .sample    (sampleBus[c*SAMPLE_W +: SAMPLE_W]),
        .threshold (thresholdBus[c*SAMPLE_W +: SAMPLE_W]),
        .pulseOn   (pulseVec[c])
      );
    end
  endgenerate

  multDatapath #(
    .NUM_CHAN (NUM_CHAN),
    .FIELD_W  (FIELD_W),
    .DAC_W    (DAC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .pulseVec (pulseVec),
    .dacCode  (dacCode)
  );
endmodule

// File: rtl/multDacChecker.sv
module multDacChecker #(
  parameter int NUM_CHAN  = 8,
  parameter int PULSE_LEN = 5,
  parameter int FIELD_W   = 4,
  parameter int DAC_W     = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic [1:0]          fieldSel,
  input logic [NUM_CHAN-1:0] pulseVec,
  input logic [DAC_W-1:0]    dacCode
);
  localparam logic [DAC_W-1:0] LOW_MASK = DAC_W'((1 << FIELD_W) - 1);

  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_zero_R1: assert (dacCode == '0);
    end
  end

  // R7: disable zeroes output and clears pulses
  assert_off_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> dacCode == '0);
  assert_off_pulses_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> pulseVec == '0);

  // R5: field value equals last cycle's active pulse count
  assert_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> ((dacCode >> (FIELD_W * $past(fieldSel))) == DAC_W'($past($countones(pulseVec)))));

  // R6: nothing outside the selected field
  assert_field_R6: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> (dacCode & ~(LOW_MASK << (FIELD_W * $past(fieldSel)))) == '0);

  generate
    if (PULSE_LEN > 1) begin : g_width
      for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
        assert_min_width_R3: assert property (@(posedge clk) disable iff (!rstN)
          (enable && $rose(pulseVec[c])) |=> (pulseVec[c] || !$past(enable)));
      end
    end
  endgenerate
endmodule

bind chanMultiplicityDac multDacChecker #(
  .NUM_CHAN  (NUM_CHAN),
  .PULSE_LEN (PULSE_LEN),
  .FIELD_W   (FIELD_W),
  .DAC_W     (DAC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .fieldSel (fieldSel),
  .pulseVec (pulseVec),
  .dacCode  (dacCode)
);

// File: tb/chanMultiplicityDac_tb.sv
module chanMultiplicityDac_tb;
  localparam int NCH = 8;
  localparam int PLEN = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic [NCH*8-1:0]  sampleBus;
  logic [NCH*8-1:0]  thresholdBus;
  logic [1:0]        fieldSel = 2'd0;
  logic [15:0]       dacCode;

  logic [7:0] smp [NCH];
  logic [7:0] thr [NCH];

  int prevM [NCH];
  int cntM  [NCH];
  logic [15:0] expDac;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      sampleBus[c*8 +: 8]    = smp[c];
      thresholdBus[c*8 +: 8] = thr[c];
    end
  end

  chanMultiplicityDac #(.PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .sampleBus(sampleBus), .thresholdBus(thresholdBus),
    .fieldSel(fieldSel), .dacCode(dacCode)
  );

  task automatic checkVal(input string tag, input logic [15:0] exp);
    checks++;
    if (dacCode !== exp) begin
      errors++;
      $display("FAIL %s: dacCode actual %h expected %h", tag, dacCode, exp);
    end
  endtask

  task automatic modelReset();
    for (int c = 0; c < NCH; c++) begin
      prevM[c] = 255;
      cntM[c]  = 0;
    end
    expDac = '0;
  endtask

  // one clock: update model at the edge, check at the falling edge
  task automatic step(input string tag);
    int act;
    @(posedge clk);
    act = 0;
    for (int c = 0; c < NCH; c++) if (cntM[c] > 0) act++;
    expDac = enable ? (16'(act) << (4 * fieldSel)) : 16'h0;
    for (int c = 0; c < NCH; c++) begin
      if (!enable) cntM[c] = 0;
      else if (prevM[c] <= int'(thr[c]) && int'(smp[c]) > int'(thr[c])) cntM[c] = PLEN;
      else if (cntM[c] > 0) cntM[c] = cntM[c] - 1;
      prevM[c] = int'(smp[c]);
    end
    @(negedge clk);
    checkVal(tag, expDac);
  endtask

  task automatic setAll(input logic [7:0] s, input logic [7:0] t);
    for (int c = 0; c < NCH; c++) begin
      smp[c] = s;
      thr[c] = t;
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: cycles actual %0d expected below 200000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed1);
    setAll(8'd200, 8'd100);
    modelReset();
    repeat (3) @(negedge clk);
    checkVal("R1 reset", 16'h0000);
    rstN = 1'b1;
    enable = 1'b1;
    // R10: first sample above threshold after reset is no crossing
    step("R10 first sample");
    step("R10 first sample");
    checkVal("R10 no pulse", 16'h0000);

    // R9: go low, then exactly at threshold
    setAll(8'd50, 8'd100);
    step("R9 low");
    setAll(8'd100, 8'd100);
    repeat (3) step("R9 equal");
    checkVal("R9 equal no pulse", 16'h0000);

    // R2/R3: channel 0 crosses and stays above
    setAll(8'd50, 8'd100);
    step("R2 low");
    smp[0] = 8'd150;
    step("R2 cross edge");
    for (int k = 0; k < PLEN; k++) begin
      step("R3 width");
      checkVal("R3 width explicit", 16'h0001);
    end
    repeat (3) step("R2 hold above");
    checkVal("R2 no restart", 16'h0000);

    // R4: retrigger channel 1 while active, others cross at same time
    setAll(8'd50, 8'd100);
    step("R4 low");
    smp[1] = 8'd150;
    step("R4 first cross");
    smp[1] = 8'd60;
    step("R4 drop");
    smp[1] = 8'd160; smp[2] = 8'd170; smp[3] = 8'd101;
    step("R4 recross");
    for (int k = 0; k < PLEN + 2; k++) step("R4 extended");

    // R5: all channels at once
    setAll(8'd50, 8'd100);
    step("R5 low");
    setAll(8'd250, 8'd100);
    step("R5 all cross");
    step("R5 all");
    checkVal("R5 eight", 16'h0008);

    // R6: move field while pulses live
    fieldSel = 2'd1; step("R6 field1"); checkVal("R6 field1 explicit", 16'h0080);
    fieldSel = 2'd2; step("R6 field2"); checkVal("R6 field2 explicit", 16'h0800);
    fieldSel = 2'd3; step("R6 field3"); checkVal("R6 field3 explicit", 16'h8000);
    fieldSel = 2'd0;
    repeat (PLEN) step("R6 drain");

    // R8: independent thresholds
    for (int c = 0; c < NCH; c++) begin
      smp[c] = 8'd50;
      thr[c] = (c % 2 == 0) ? 8'd100 : 8'd130;
    end
    step("R8 low");
    for (int c = 0; c < NCH; c++) smp[c] = 8'd120;
    step("R8 cross");
    step("R8 count");
    checkVal("R8 four channels", 16'h0004);

    // R7: disable with pulses active, crossings ignored while off
    enable = 1'b0;
    step("R7 off");
    checkVal("R7 off explicit", 16'h0000);
    setAll(8'd50, 8'd100);
    step("R7 off low");
    setAll(8'd200, 8'd100);
    step("R7 off cross");
    enable = 1'b1;
    repeat (3) step("R7 resume");
    checkVal("R7 ignored crossing", 16'h0000);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 49) == 0) begin
        for (int c = 0; c < NCH; c++) thr[c] = 8'($urandom_range(20, 230));
      end
      for (int c = 0; c < NCH; c++) begin
        int v;
        v = int'(thr[c]) + int'($urandom_range(0, 16)) - 8;
        smp[c] = 8'(v);
      end
      if ($urandom_range(0, 19) == 0) fieldSel = 2'($urandom_range(0, 3));
      enable = ($urandom_range(0, 29) != 0);
      step("R5 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule